// File: doc/BRIEF.md
# Derived Bus Clock Frequency Calculator

This block works out, in hertz, the frequency of one derived bus clock from the clock tree configuration fields it is given. The tree starts from a fixed 24 MHz reference. A system PLL multiplies the reference by 20 or by 22. Two phase-fractional taps each give PLL×18/frac. A four-way root selector feeds a chain of three integer post-dividers: bus, register bus and peripheral.

A caller sets the field inputs and a clock identifier, then pulses `start_i`. The block captures every field in that cycle and walks the tree one stage at a time. A single shared restoring divider with 64-bit operands performs every division. When the result is ready, `done_o` pulses for one cycle, and `freq_o` and `err_o` hold that result until the next completion. No real clock waveform is produced.

Top module: `clk_freq_calc`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `freq_o` are all 0.
- R2: With `root_sel_i`=0 the root equals the PLL rate: 528,000,000 Hz when `pll_mul_i`=1 and 480,000,000 Hz when it is 0. For identifier 1 (bus clock) the result is floor(root/(1+`ahb_div_i`)).
- R3: `root_sel_i` chooses the root as follows. Code 1 is floor(PLL×18/`pfd2_frac_i`). Code 2 is floor(PLL×18/`pfd0_frac_i`). Code 3 is floor(floor(PLL×18/`pfd2_frac_i`)/2).
- R4: Identifier 2 (register bus) gives floor(bus/(1+`ipg_div_i`)). Identifier 3 (peripheral) gives floor(register bus/(1+`per_div_i`)). Every stage truncates.
- R5: Identifier 0 returns 0 and identifier 4 returns 32768. Neither sets `err_o`.
- R6: Identifiers 5, 6 and 7 return 0 with `err_o`=1.
- R7: If the selected root uses a fractional tap whose field is 0, the result is 0 with `err_o`=1. A zero in the tap that is not selected has no effect.
- R8: `done_o` is high for exactly one cycle per computation. `freq_o` and `err_o` change only in a cycle where `done_o` is high.
- R9: Field and identifier values are taken in the cycle `start_i` is seen. Changes after that cycle do not alter the result.
- R10: `busy_o` is high from the cycle after an accepted start until `done_o`. A `start_i` seen while busy is ignored and causes no extra `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| clk_sel_i | input | 3 | Requested clock identifier |
| pll_mul_i | input | 1 | PLL multiplier select: 1 gives ×22, 0 gives ×20 |
| pfd0_frac_i | input | 6 | Fractional field of tap 0 |
| pfd2_frac_i | input | 6 | Fractional field of tap 2 |
| root_sel_i | input | 2 | Root source select |
| ahb_div_i | input | 3 | Bus post-divider field |
| ipg_div_i | input | 2 | Register bus post-divider field |
| per_div_i | input | 6 | Peripheral post-divider field |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result strobe |
| freq_o | output | 64 | Resulting frequency in Hz |
| err_o | output | 1 | Result is an error (unsupported identifier or zero tap field) |

## Verification
Directed cases cover each root code with both PLL multipliers. They separate tap 0 from tap 2 by giving the two taps different nonzero fractions, and they separate code 3 from code 1 by the extra halving. Chain depth is probed with identifiers 1, 2 and 3 on the same fields, so a stage that is skipped or repeated changes the value. Fixed and unsupported identifiers are tried against zero fractional fields to tell error from non-error cases. Seeded random fields and identifiers, with zero fractions injected now and then, then sweep the truncation behaviour across all the divider combinations.

// File: rtl/cfc_pkg.sv
`timescale 1ns/1ps
package cfc_pkg;
  localparam int unsigned REF_HZ  = 24000000;
  localparam int unsigned MUL_LO  = 20;
  localparam int unsigned MUL_HI  = 22;
  localparam int unsigned PFD_MUL = 18;
  localparam int unsigned SLOW_HZ = 32768;

  localparam int FREQ_W = 64;
  localparam int DVS_W  = 8;
  localparam int FRAC_W = 6;
  localparam int AHB_W  = 3;
  localparam int IPG_W  = 2;
  localparam int PER_W  = 6;
  localparam int ID_W   = 3;

  localparam logic [ID_W-1:0] CID_NONE = 3'd0;
  localparam logic [ID_W-1:0] CID_AHB  = 3'd1;
  localparam logic [ID_W-1:0] CID_IPG  = 3'd2;
  localparam logic [ID_W-1:0] CID_PER  = 3'd3;
  localparam logic [ID_W-1:0] CID_SLOW = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PLAN, ST_FRAC, ST_HALF, ST_AHB, ST_IPG, ST_PER
  } stage_e;
endpackage

// File: rtl/cfc_root.sv
`timescale 1ns/1ps
module cfc_root
  import cfc_pkg::*;
(
  input  logic              pll_mul_i,
  input  logic [1:0]        root_sel_i,
  input  logic [FRAC_W-1:0] frac0_i,
  input  logic [FRAC_W-1:0] frac2_i,
  output logic [FREQ_W-1:0] pll_hz_o,
  output logic [FREQ_W-1:0] pfd_num_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              frac_err_o
);
  localparam logic [FREQ_W-1:0] PLL_HI = FREQ_W'(REF_HZ * MUL_HI);
  localparam logic [FREQ_W-1:0] PLL_LO = FREQ_W'(REF_HZ * MUL_LO);

  assign pll_hz_o   = pll_mul_i ? PLL_HI : PLL_LO;
  assign pfd_num_o  = pll_hz_o * FREQ_W'(PFD_MUL);
  assign frac_o     = (root_sel_i == 2'd2) ? frac0_i : frac2_i;
  assign frac_err_o = (root_sel_i != 2'd0) && (frac_o == '0);
endmodule

// File: rtl/cfc_div.sv
`timescale 1ns/1ps
module cfc_div #(
  parameter int DW = 64,
  parameter int VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int CW = $clog2(DW + 1);

  logic          run_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [VW-1:0] rem_q, dvs_q;
  logic [DW-1:0] quot_q, dend_q;
  logic [VW:0]   rem_sh, rem_nx;
  logic          ge;

  assign rem_sh = {rem_q, quot_q[DW-1]};
  assign ge     = rem_sh >= {1'b0, dvs_q};
  assign rem_nx = ge ? (rem_sh - {1'b0, dvs_q}) : rem_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      quot_q <= '0;
      dend_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        dvs_q  <= divisor_i;
        quot_q <= dividend_i;
        dend_q <= dividend_i;
      end else if (run_q) begin
        rem_q  <= rem_nx[VW-1:0];
        quot_q <= {quot_q[DW-2:0], ge};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CW'(DW - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;

  assert_div_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_div_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((quot_q * DW'(dvs_q)) + DW'(rem_q) == dend_q) && (rem_q < dvs_q));
endmodule

// File: rtl/clk_freq_calc.sv
`timescale 1ns/1ps
module clk_freq_calc
  import cfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   clk_sel_i,
  input  logic              pll_mul_i,
  input  logic [FRAC_W-1:0] pfd0_frac_i,
  input  logic [FRAC_W-1:0] pfd2_frac_i,
  input  logic [1:0]        root_sel_i,
  input  logic [AHB_W-1:0]  ahb_div_i,
  input  logic [IPG_W-1:0]  ipg_div_i,
  input  logic [PER_W-1:0]  per_div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              err_o
);
  stage_e            st_q, go_st, nxt;
  logic [ID_W-1:0]   id_q;
  logic              mul_q;
  logic [FRAC_W-1:0] f0_q, f2_q;
  logic [1:0]        src_q;
  logic [AHB_W-1:0]  ahb_q;
  logic [IPG_W-1:0]  ipg_q;
  logic [PER_W-1:0]  per_q;

  logic [FREQ_W-1:0] pll_hz, pfd_num, fin_val, go_val, go_dvd, dvd_q, div_q;
  logic [FRAC_W-1:0] frac_sel;
  logic [DVS_W-1:0]  go_dvs, dvs_q;
  logic              frac_err, fin, fin_err, go, launch_q, div_done;
  logic              done_q, err_q;
  logic [FREQ_W-1:0] freq_q;
  logic              chain_id;

  cfc_root u_root (
    .pll_mul_i (mul_q),
    .root_sel_i(src_q),
    .frac0_i   (f0_q),
    .frac2_i   (f2_q),
    .pll_hz_o  (pll_hz),
    .pfd_num_o (pfd_num),
    .frac_o    (frac_sel),
    .frac_err_o(frac_err)
  );

  cfc_div #(.DW(FREQ_W), .VW(DVS_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (launch_q),
    .dividend_i(dvd_q),
    .divisor_i (dvs_q),
    .done_o    (div_done),
    .quot_o    (div_q)
  );

  function automatic stage_e next_stage(stage_e s, logic [1:0] src, logic [ID_W-1:0] id);
    stage_e r;
    case (s)
      ST_FRAC: r = (src == 2'd3) ? ST_HALF : ST_AHB;
      ST_HALF: r = ST_AHB;
      ST_AHB:  r = (id == CID_AHB) ? ST_IDLE : ST_IPG;
      ST_IPG:  r = (id == CID_IPG) ? ST_IDLE : ST_PER;
      default: r = ST_IDLE;
    endcase
    return r;
  endfunction

  assign chain_id = (id_q == CID_AHB) || (id_q == CID_IPG) || (id_q == CID_PER);

  always_comb begin
    fin     = 1'b0;
    fin_val = '0;
    fin_err = 1'b0;
    go      = 1'b0;
    go_st   = ST_IDLE;
    go_val  = '0;
    nxt     = next_stage(st_q, src_q, id_q);
    case (st_q)
      ST_IDLE: ;
      ST_PLAN: begin
        if (id_q == CID_NONE) begin
          fin = 1'b1;
        end else if (id_q == CID_SLOW) begin
          fin     = 1'b1;
          fin_val = FREQ_W'(SLOW_HZ);
        end else if (!chain_id || frac_err) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end else begin
          go     = 1'b1;
          go_st  = (src_q == 2'd0) ? ST_AHB : ST_FRAC;
          go_val = pll_hz;
        end
      end
      default: begin
        if (div_done) begin
          if (nxt == ST_IDLE) begin
            fin     = 1'b1;
            fin_val = div_q;
          end else begin
            go     = 1'b1;
            go_st  = nxt;
            go_val = div_q;
          end
        end
      end
    endcase
  end

  always_comb begin
    go_dvd = (go_st == ST_FRAC) ? pfd_num : go_val;
    case (go_st)
      ST_FRAC: go_dvs = DVS_W'(frac_sel);
      ST_HALF: go_dvs = DVS_W'(2);
      ST_AHB:  go_dvs = DVS_W'(ahb_q) + DVS_W'(1);
      ST_IPG:  go_dvs = DVS_W'(ipg_q) + DVS_W'(1);
      ST_PER:  go_dvs = DVS_W'(per_q) + DVS_W'(1);
      default: go_dvs = DVS_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      id_q     <= '0;
      mul_q    <= 1'b0;
      f0_q     <= '0;
      f2_q     <= '0;
      src_q    <= '0;
      ahb_q    <= '0;
      ipg_q    <= '0;
      per_q    <= '0;
      dvd_q    <= '0;
      dvs_q    <= '0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      freq_q   <= '0;
    end else begin
      done_q   <= fin;
      launch_q <= go;
      if (st_q == ST_IDLE && start_i) begin
        st_q  <= ST_PLAN;
        id_q  <= clk_sel_i;
        mul_q <= pll_mul_i;
        f0_q  <= pfd0_frac_i;
        f2_q  <= pfd2_frac_i;
        src_q <= root_sel_i;
        ahb_q <= ahb_div_i;
        ipg_q <= ipg_div_i;
        per_q <= per_div_i;
      end
      if (fin) begin
        st_q   <= ST_IDLE;
        freq_q <= fin_val;
        err_q  <= fin_err;
      end
      if (go) begin
        st_q  <= go_st;
        dvd_q <= go_dvd;
        dvs_q <= go_dvs;
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign freq_o = freq_q;
  assign err_o  = err_q;

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(freq_o) && $stable(err_o)));
  assert_err_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (freq_o == '0));
  assert_done_after_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  assert_zero_frac_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PLAN && frac_err && chain_id) |=> (done_o && err_o));
  assert_no_div_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_q |-> (dvs_q != '0));
endmodule

// File: tb/sim_clk_freq_calc.sv
`timescale 1ns/1ps
module sim_clk_freq_calc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  clk_sel_i = '0;
  logic        pll_mul_i = 1'b0;
  logic [5:0]  pfd0_frac_i = '0, pfd2_frac_i = '0;
  logic [1:0]  root_sel_i = '0;
  logic [2:0]  ahb_div_i = '0;
  logic [1:0]  ipg_div_i = '0;
  logic [5:0]  per_div_i = '0;
  logic        busy_o, done_o, err_o;
  logic [63:0] freq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  clk_freq_calc u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .clk_sel_i(clk_sel_i),
    .pll_mul_i(pll_mul_i), .pfd0_frac_i(pfd0_frac_i), .pfd2_frac_i(pfd2_frac_i),
    .root_sel_i(root_sel_i), .ahb_div_i(ahb_div_i), .ipg_div_i(ipg_div_i),
    .per_div_i(per_div_i), .busy_o(busy_o), .done_o(done_o), .freq_o(freq_o),
    .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic void model(input logic [2:0] id, input logic m,
      input logic [5:0] f0, input logic [5:0] f2, input logic [1:0] s,
      input logic [2:0] a, input logic [1:0] b, input logic [5:0] c,
      output logic [63:0] f, output logic e);
    logic [63:0] pll, v;
    logic [5:0]  fr;
    f = 0; e = 0;
    pll = m ? 64'd528000000 : 64'd480000000;
    fr  = (s == 2'd2) ? f0 : f2;
    if (id == 3'd0) f = 0;
    else if (id == 3'd4) f = 64'd32768;
    else if (id > 3'd4) e = 1;
    else if (s != 2'd0 && fr == 6'd0) e = 1;
    else begin
      v = (s == 2'd0) ? pll : (pll * 64'd18) / 64'(fr);
      if (s == 2'd3) v = v / 64'd2;
      v = v / (64'(a) + 64'd1);
      if (id >= 3'd2) v = v / (64'(b) + 64'd1);
      if (id == 3'd3) v = v / (64'(c) + 64'd1);
      f = v;
    end
  endfunction

  task automatic drive(input logic [2:0] id, input logic m, input logic [5:0] f0,
      input logic [5:0] f2, input logic [1:0] s, input logic [2:0] a,
      input logic [1:0] b, input logic [5:0] c);
    clk_sel_i = id; pll_mul_i = m; pfd0_frac_i = f0; pfd2_frac_i = f2;
    root_sel_i = s; ahb_div_i = a; ipg_div_i = b; per_div_i = c;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    if (!done_o) chk(1'b0, req, "done timeout", 0, 1);
  endtask

  task automatic run(input string req, input logic [2:0] id, input logic m,
      input logic [5:0] f0, input logic [5:0] f2, input logic [1:0] s,
      input logic [2:0] a, input logic [1:0] b, input logic [5:0] c);
    logic [63:0] ef;
    logic        ee;
    model(id, m, f0, f2, s, a, b, c, ef, ee);
    drive(id, m, f0, f2, s, a, b, c);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after start", 64'(busy_o), 1);
    wait_done(req);
    chk(freq_o == ef, req, "freq", freq_o, ef);
    chk(err_o == ee, req, "err", 64'(err_o), 64'(ee));
    @(negedge clk_i);
    chk(done_o == 1'b0 && freq_o == ef && busy_o == 1'b0, "R8", "pulse/hold",
        64'(done_o), 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && err_o == 0 && freq_o == 0, "R1", "reset state",
        freq_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && err_o == 0 && freq_o == 0, "R1", "after release",
        freq_o, 0);

    run("R2", 3'd1, 1'b1, 6'd20, 6'd20, 2'd0, 3'd3, 2'd0, 6'd0);
    run("R2", 3'd1, 1'b0, 6'd20, 6'd20, 2'd0, 3'd0, 2'd0, 6'd0);
    run("R3", 3'd1, 1'b1, 6'd17, 6'd24, 2'd1, 3'd1, 2'd0, 6'd0);
    run("R3", 3'd1, 1'b1, 6'd35, 6'd16, 2'd2, 3'd0, 2'd0, 6'd0);
    run("R3", 3'd1, 1'b0, 6'd12, 6'd30, 2'd3, 3'd0, 2'd0, 6'd0);
    run("R3", 3'd1, 1'b1, 6'd63, 6'd13, 2'd3, 3'd2, 2'd0, 6'd0);
    run("R4", 3'd2, 1'b1, 6'd19, 6'd27, 2'd1, 3'd2, 2'd3, 6'd5);
    run("R4", 3'd3, 1'b1, 6'd19, 6'd27, 2'd1, 3'd2, 2'd3, 6'd5);
    run("R4", 3'd3, 1'b1, 6'd1, 6'd1, 2'd2, 3'd7, 2'd3, 6'd63);
    run("R4", 3'd1, 1'b1, 6'd1, 6'd2, 2'd2, 3'd0, 2'd0, 6'd0);
    run("R5", 3'd0, 1'b1, 6'd0, 6'd0, 2'd1, 3'd1, 2'd1, 6'd1);
    run("R5", 3'd4, 1'b0, 6'd0, 6'd0, 2'd3, 3'd5, 2'd2, 6'd9);
    run("R6", 3'd5, 1'b1, 6'd20, 6'd20, 2'd0, 3'd0, 2'd0, 6'd0);
    run("R6", 3'd7, 1'b0, 6'd20, 6'd20, 2'd2, 3'd1, 2'd1, 6'd1);
    run("R7", 3'd1, 1'b1, 6'd20, 6'd0, 2'd1, 3'd0, 2'd0, 6'd0);
    run("R7", 3'd3, 1'b1, 6'd0, 6'd20, 2'd2, 3'd1, 2'd1, 6'd1);
    run("R7", 3'd2, 1'b0, 6'd18, 6'd0, 2'd2, 3'd1, 2'd1, 6'd0);
    run("R7", 3'd1, 1'b1, 6'd0, 6'd0, 2'd0, 3'd2, 2'd0, 6'd0);

    // R9 and R10: fields changed and start re-pulsed while busy
    begin
      logic [63:0] ef;
      logic        ee;
      int          extra = 0;
      model(3'd3, 1'b1, 6'd22, 6'd29, 2'd3, 3'd1, 2'd2, 6'd3, ef, ee);
      drive(3'd3, 1'b1, 6'd22, 6'd29, 2'd3, 3'd1, 2'd2, 6'd3);
      start_i = 1'b1;
      @(negedge clk_i);
      drive(3'd4, 1'b0, 6'd0, 6'd0, 2'd0, 3'd7, 2'd3, 6'd63);
      @(negedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      wait_done("R9");
      chk(freq_o == ef && err_o == ee, "R9", "captured fields", freq_o, ef);
      for (int i = 0; i < 500; i++) begin
        @(negedge clk_i);
        if (done_o) extra++;
      end
      chk(extra == 0, "R10", "extra done", 64'(extra), 0);
      chk(freq_o == ef, "R8", "hold while idle", freq_o, ef);
    end

    for (int k = 0; k < 120; k++) begin
      logic [2:0] id;
      logic [5:0] f0, f2;
      id = 3'($urandom_range(0, 7));
      if (k % 3 != 0) id = 3'($urandom_range(1, 3));
      f0 = 6'($urandom);
      f2 = 6'($urandom);
      if ($urandom_range(0, 9) == 0) f0 = 6'd0;
      if ($urandom_range(0, 9) == 0) f2 = 6'd0;
      run("R3/R4 random", id, 1'($urandom), f0, f2, 2'($urandom), 3'($urandom),
          2'($urandom), 6'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule